// File: doc/BRIEF.md
# Oscillator-Gated Reset Controller with Bus-Pattern Test Override

This block produces the internal reset for a small clock/calendar register file that is reached over a two-wire serial bus. The timekeeping oscillator is sampled in the system clock domain. A watchdog counter declares the oscillator stopped when no oscillator edge has arrived for a set number of system clocks. While the oscillator is stopped, the internal reset holds the serial interface logic and the register file in their initial state, and the interface clears its register address pointer to 00h.

Crystal start-up is slow, so a test override can end the reset early. Both bus lines pass through synchronisers. When they then follow a fixed four-phase toggle pattern and every phase lasts long enough, the override flag sets and the internal reset releases at once, even with the oscillator stopped. The pattern is honoured only while an enable bit is armed. The enable is bit 3 of the control byte at register address 0. Writing that bit to 0 cancels the override and disarms entry. Writing it back to 1 arms entry again.

The block also presents, as constant vectors, the value each register takes when reset is applied and the mask of bits that reset actually loads.

Top module: `rstov_ctrl`

## Requirements
- R1: While `por_n` is low, `core_rst` is 1 and `ovr_act` is 0.
- R2: With the override inactive, `core_rst` is 1 once no rising oscillator edge has been seen for `STOP_LIM` clocks.
- R3: While rising oscillator edges arrive at intervals shorter than `STOP_LIM` clocks, `core_rst` is 0.
- R4: The bus pattern must run in this order: {SDA,SCL} = 11, then 01, then 00, then 10, then back to 11, with each phase held for at least `MIN_PH` clocks. If entry is armed when this pattern completes, `ovr_act` goes to 1 and `core_rst` goes to 0 while the oscillator is stopped.
- R5: If any phase of the pattern lasts fewer than `MIN_PH` clocks, the override is not entered.
- R6: If a line changes out of the order given in R4, the detector returns to idle and the override is not entered.
- R7: A write to address 0 with data bit 3 = 0 clears `ovr_act`. If the oscillator is stopped, `core_rst` then returns to 1.
- R8: After such a write, a complete pattern is ignored until bit 3 is written as 1. A write of 1 arms entry but does not set `ovr_act` by itself.
- R9: Writing bit 3 = 0 while the oscillator runs leaves `core_rst` at 0.
- R10: A write to any address other than 0 leaves `ovr_act` unchanged, whatever the data.
- R11: A low pulse on `por_n` clears an active override.
- R12: Register i occupies `init_val`/`init_msk` bits [8i+7:8i], and a mask bit of 1 means reset loads that bit.
  - Register 0 loads 08h into all bits.
  - Register 1 loads 0 into bits 5:0.
  - Registers 2, 3, 9, 10, 11 and 12 load 1 into bit 7 only.
  - Register 13 loads bit 7 = 1 and bits 1:0 = 0.
  - Register 14 loads bit 7 = 0 and bits 1:0 = 11b.
  - No other register bit is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| osc_clk | input | 1 | Raw timekeeping oscillator, asynchronous |
| sda_in | input | 1 | Raw serial data line level |
| scl_in | input | 1 | Raw serial clock line level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | 8 | Register write data |
| core_rst | output | 1 | Internal reset, active high |
| ovr_act | output | 1 | Test override active |
| init_val | output | NREG*8 | Value each register loads on reset |
| init_msk | output | NREG*8 | Bits each register loads on reset |

## Verification
The hardest state to reach from the ports is a complete, correctly timed pattern that the block must ignore because entry has been disarmed. Reaching it takes several steps. The stimulus first enters the override and then clears it with a control write. It then replays a full valid pattern with the oscillator still stopped, so that only the missing arm keeps reset asserted. After that, a write of 1 alone must not set the flag, and the next valid pattern must. The short-phase and out-of-order cases are run immediately after re-arming, so each miss is caused by timing or ordering alone.

// File: rtl/rstov_pkg.sv
`timescale 1ns/1ps
package rstov_pkg;

   localparam int unsigned BYTE_W    = 8;
   localparam int unsigned CTL_ADDR  = 0;
   localparam int unsigned TESTC_BIT = 3;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_HH,
      PH_LH,
      PH_LL,
      PH_HL
   } ph_e;

   typedef struct packed {
      logic [BYTE_W-1:0] val;
      logic [BYTE_W-1:0] msk;
   } rinit_t;

   function automatic rinit_t reg_init(input int unsigned idx);
      rinit_t r;
      r.val = '0;
      r.msk = '0;
      case (idx)
         0:                      begin r.val = 8'h08; r.msk = 8'hFF; end
         1:                      begin r.val = 8'h00; r.msk = 8'h3F; end
         2, 3, 9, 10, 11, 12:    begin r.val = 8'h80; r.msk = 8'h80; end
         13:                     begin r.val = 8'h80; r.msk = 8'h83; end
         14:                     begin r.val = 8'h03; r.msk = 8'h83; end
         default:                ;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/rstov_sync.sv
`timescale 1ns/1ps
module rstov_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("rstov_sync: STAGES must be 2 or more");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/rstov_osc_watch.sv
`timescale 1ns/1ps
module rstov_osc_watch #(
   parameter int unsigned STOP_LIM    = 255,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          BOTH_EDGES  = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_raw,
   output logic osc_run
);

   localparam int unsigned CW = $clog2(STOP_LIM + 1);
   localparam logic [CW-1:0] LIM = CW'(STOP_LIM);

   if (STOP_LIM < 2) begin : g_bad_lim
      $error("rstov_osc_watch: STOP_LIM must be 2 or more");
   end

   logic          osc_s;
   logic          osc_d;
   logic          edge_seen;
   logic [CW-1:0] idle_cnt;

   rstov_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (osc_raw),
      .q     (osc_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) osc_d <= 1'b0;
      else        osc_d <= osc_s;
   end

   if (BOTH_EDGES) begin : g_both
      assign edge_seen = osc_s ^ osc_d;
   end else begin : g_rise
      assign edge_seen = osc_s & ~osc_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               idle_cnt <= LIM;
      else if (edge_seen)       idle_cnt <= '0;
      else if (idle_cnt != LIM) idle_cnt <= idle_cnt + 1'b1;
   end

   assign osc_run = (idle_cnt != LIM);

endmodule

// File: rtl/rstov_seq_det.sv
`timescale 1ns/1ps
module rstov_seq_det
   import rstov_pkg::*;
#(
   parameter int unsigned MIN_PH = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sda,
   input  logic scl,
   output logic hit
);

   localparam int unsigned CW = $clog2(MIN_PH + 1);
   localparam logic [CW-1:0] LONG = CW'(MIN_PH);

   if (MIN_PH < 1) begin : g_bad_min
      $error("rstov_seq_det: MIN_PH must be 1 or more");
   end

   ph_e           st, nxt;
   logic [CW-1:0] cnt;
   logic          long_en;
   logic          done;
   logic [1:0]    bus;

   assign bus     = {sda, scl};
   assign long_en = (cnt == LONG);

   always_comb begin
      nxt  = st;
      done = 1'b0;
      unique case (st)
         PH_IDLE: if (bus == 2'b11) nxt = PH_HH;
         PH_HH: begin
            if (bus != 2'b11) nxt = (bus == 2'b01 && long_en) ? PH_LH : PH_IDLE;
         end
         PH_LH: begin
            if (bus != 2'b01) nxt = (bus == 2'b00 && long_en) ? PH_LL : PH_IDLE;
         end
         PH_LL: begin
            if (bus != 2'b00) nxt = (bus == 2'b10 && long_en) ? PH_HL : PH_IDLE;
         end
         PH_HL: begin
            if (bus != 2'b10) begin
               nxt  = PH_IDLE;
               done = (bus == 2'b11) && long_en;
            end
         end
         default: nxt = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= PH_IDLE;
         cnt <= '0;
         hit <= 1'b0;
      end else begin
         st  <= nxt;
         hit <= done;
         if (nxt != st)     cnt <= '0;
         else if (!long_en) cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/rstov_ctrl.sv
`timescale 1ns/1ps
module rstov_ctrl
   import rstov_pkg::*;
#(
   parameter int unsigned AW          = 4,
   parameter int unsigned NREG        = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned MIN_PH      = 64,
   parameter int unsigned STOP_LIM    = 255,
   parameter bit          OSC_BOTH_EDGES = 1'b0
) (
   input  logic                 clk,
   input  logic                 por_n,
   input  logic                 osc_clk,
   input  logic                 sda_in,
   input  logic                 scl_in,
   input  logic                 wr_en,
   input  logic [AW-1:0]        wr_addr,
   input  logic [BYTE_W-1:0]    wr_data,
   output logic                 core_rst,
   output logic                 ovr_act,
   output logic [NREG*BYTE_W-1:0] init_val,
   output logic [NREG*BYTE_W-1:0] init_msk
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("rstov_ctrl: SYNC_STAGES must be 2 or more");
   end
   if (NREG < 16 || NREG > (1 << AW)) begin : g_bad_nreg
      $error("rstov_ctrl: NREG must cover the 16 registers and fit the address");
   end

   logic [1:0] bus_s;
   logic       osc_run;
   logic       seq_hit;
   logic       arm_q;
   logic       ovr_q;
   logic       rst_q;
   logic       ctl_wr;
   logic       testc_w;
   logic       unused_wr;

   rstov_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
      .clk   (clk),
      .rst_n (por_n),
      .d     ({sda_in, scl_in}),
      .q     (bus_s)
   );

   rstov_osc_watch #(
      .STOP_LIM    (STOP_LIM),
      .SYNC_STAGES (SYNC_STAGES),
      .BOTH_EDGES  (OSC_BOTH_EDGES)
   ) u_osc (
      .clk     (clk),
      .rst_n   (por_n),
      .osc_raw (osc_clk),
      .osc_run (osc_run)
   );

   rstov_seq_det #(.MIN_PH(MIN_PH)) u_det (
      .clk   (clk),
      .rst_n (por_n),
      .sda   (bus_s[1]),
      .scl   (bus_s[0]),
      .hit   (seq_hit)
   );

   assign ctl_wr    = wr_en && (wr_addr == AW'(CTL_ADDR));
   assign testc_w   = wr_data[TESTC_BIT];
   assign unused_wr = ^wr_data;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         arm_q <= 1'b1;
         ovr_q <= 1'b0;
         rst_q <= 1'b1;
      end else begin
         if (ctl_wr) arm_q <= testc_w;
         if (ctl_wr && !testc_w)     ovr_q <= 1'b0;
         else if (seq_hit && arm_q)  ovr_q <= 1'b1;
         rst_q <= !(osc_run || ovr_q);
      end
   end

   assign core_rst = rst_q;
   assign ovr_act  = ovr_q;

   for (genvar g = 0; g < NREG; g++) begin : g_init
      localparam rinit_t RI = reg_init(g);
      assign init_val[g*BYTE_W +: BYTE_W] = RI.val;
      assign init_msk[g*BYTE_W +: BYTE_W] = RI.msk;
   end

endmodule

// File: rtl/rstov_ctrl_chk.sv
`timescale 1ns/1ps
module rstov_ctrl_chk
   import rstov_pkg::*;
#(
   parameter int unsigned AW = 4
) (
   input logic              clk,
   input logic              por_n,
   input logic              osc_run,
   input logic              seq_hit,
   input logic              arm_q,
   input logic              wr_en,
   input logic [AW-1:0]     wr_addr,
   input logic [BYTE_W-1:0] wr_data,
   input logic              core_rst,
   input logic              ovr_act
);

   a_r2_stopped_holds_rst: assert property (@(posedge clk) disable iff (!por_n)
      (!osc_run && !ovr_act) |=> core_rst);

   a_r3_running_releases: assert property (@(posedge clk) disable iff (!por_n)
      osc_run |=> !core_rst);

   a_r4_override_releases: assert property (@(posedge clk) disable iff (!por_n)
      ovr_act |=> !core_rst);

   a_r7_testc_clears: assert property (@(posedge clk) disable iff (!por_n)
      (wr_en && wr_addr == AW'(CTL_ADDR) && !wr_data[TESTC_BIT]) |=> !ovr_act);

   a_r8_entry_needs_arm: assert property (@(posedge clk) disable iff (!por_n)
      $rose(ovr_act) |-> $past(seq_hit && arm_q));

   a_r10_other_addr_keeps: assert property (@(posedge clk) disable iff (!por_n)
      (wr_en && wr_addr != AW'(CTL_ADDR) && ovr_act) |=> ovr_act);

endmodule

bind rstov_ctrl rstov_ctrl_chk #(.AW(AW)) u_chk (
   .clk      (clk),
   .por_n    (por_n),
   .osc_run  (osc_run),
   .seq_hit  (seq_hit),
   .arm_q    (arm_q),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .wr_data  (wr_data),
   .core_rst (core_rst),
   .ovr_act  (ovr_act)
);

// File: tb/rstov_ctrl_test.sv
`timescale 1ns/1ps
module rstov_ctrl_test;
   import rstov_pkg::*;

   localparam int unsigned AW = 4, NREG = 16, MIN_PH = 8, STOP_LIM = 16;

   logic clk = 1'b0, por_n = 1'b0, osc_clk = 1'b0, sda = 1'b1, scl = 1'b1, wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic          core_rst, ovr_act;
   logic [NREG*8-1:0] init_val, init_msk;
   bit osc_on = 1'b0;
   int errors = 0, checks = 0;

   typedef struct {
      string tag;
      logic  rst;
      logic  ovr;
   } exp_t;
   exp_t sb[$];

   rstov_ctrl #(.AW(AW), .NREG(NREG), .MIN_PH(MIN_PH), .STOP_LIM(STOP_LIM)) uut (
      .clk(clk), .por_n(por_n), .osc_clk(osc_clk), .sda_in(sda), .scl_in(scl),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .core_rst(core_rst), .ovr_act(ovr_act), .init_val(init_val), .init_msk(init_msk)
   );

   always #4 clk = ~clk;

   initial forever begin
      #24;
      if (osc_on) osc_clk = ~osc_clk;
   end

   function automatic void cmp(string tag, string what, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endfunction

   // monitor: pops expectations and compares at the falling edge
   initial forever begin
      exp_t e;
      @(negedge clk);
      while (sb.size() > 0) begin
         e = sb.pop_front();
         cmp(e.tag, "core_rst", 8'(core_rst), 8'(e.rst));
         cmp(e.tag, "ovr_act", 8'(ovr_act), 8'(e.ovr));
      end
   end

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic expect_st(string tag, logic r, logic o);
      exp_t e;
      e.tag = tag; e.rst = r; e.ovr = o;
      sb.push_back(e);
      @(negedge clk);
      #1;
   endtask

   task automatic wr(logic [AW-1:0] a, logic [7:0] d);
      tick(1);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      tick(1);
      wr_en = 1'b0;
   endtask

   task automatic pattern(int h0, int h1, int h2, int h3);
      sda = 1'b1; scl = 1'b1; tick(h0);
      sda = 1'b0; tick(h1);
      scl = 1'b0; tick(h2);
      sda = 1'b1; tick(h3);
      scl = 1'b1; tick(10);
   endtask

   task automatic pattern_bad_order();
      sda = 1'b1; scl = 1'b1; tick(16);
      sda = 1'b0; tick(16);
      scl = 1'b0; tick(16);
      scl = 1'b1; tick(16);   // SCL rises before SDA: out of order
      sda = 1'b1; tick(16);
      scl = 1'b0; tick(16);
      scl = 1'b1; tick(10);
   endtask

   task automatic chk_init(int idx, logic [7:0] v, logic [7:0] m);
      cmp("R12", $sformatf("init_val[%0d]", idx), init_val[idx*8 +: 8], v);
      cmp("R12", $sformatf("init_msk[%0d]", idx), init_msk[idx*8 +: 8], m);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      tick(5);
      expect_st("R1", 1'b1, 1'b0);
      chk_init(0, 8'h08, 8'hFF);
      chk_init(1, 8'h00, 8'h3F);
      chk_init(2, 8'h80, 8'h80);
      chk_init(3, 8'h80, 8'h80);
      chk_init(5, 8'h00, 8'h00);
      chk_init(9, 8'h80, 8'h80);
      chk_init(12, 8'h80, 8'h80);
      chk_init(13, 8'h80, 8'h83);
      chk_init(14, 8'h03, 8'h83);
      chk_init(15, 8'h00, 8'h00);

      por_n = 1'b1;
      tick(5);
      expect_st("R2", 1'b1, 1'b0);

      osc_on = 1'b1; tick(40);
      expect_st("R3", 1'b0, 1'b0);
      osc_on = 1'b0; tick(STOP_LIM + 20);
      expect_st("R2", 1'b1, 1'b0);

      pattern(16, 16, 16, 16);
      expect_st("R4", 1'b0, 1'b1);

      wr(4'd1, 8'h00); tick(3);
      expect_st("R10", 1'b0, 1'b1);

      wr(4'd0, 8'h00); tick(3);
      expect_st("R7", 1'b1, 1'b0);

      pattern(16, 16, 16, 16);
      expect_st("R8", 1'b1, 1'b0);
      wr(4'd0, 8'h08); tick(3);
      expect_st("R8", 1'b1, 1'b0);
      pattern(16, 16, 16, 16);
      expect_st("R8", 1'b0, 1'b1);

      wr(4'd0, 8'h00); wr(4'd0, 8'h08); tick(3);
      pattern(16, 4, 16, 16);
      expect_st("R5", 1'b1, 1'b0);
      pattern(16, 16, 16, 4);
      expect_st("R5", 1'b1, 1'b0);
      pattern_bad_order();
      expect_st("R6", 1'b1, 1'b0);

      pattern(16, 16, 16, 16);
      expect_st("R4", 1'b0, 1'b1);
      por_n = 1'b0; tick(2);
      por_n = 1'b1; tick(3);
      expect_st("R11", 1'b1, 1'b0);

      osc_on = 1'b1; tick(40);
      wr(4'd0, 8'h00); tick(3);
      expect_st("R9", 1'b0, 1'b0);
      wr(4'd0, 8'h08);
      osc_on = 1'b0; tick(STOP_LIM + 20);
      expect_st("R2", 1'b1, 1'b0);

      tick(2);
      finish_run();
   end

endmodule